// File: doc/BRIEF.md
# Vector Quad Load/Store Unit

This block moves data between a byte-addressed 4 KiB data memory and a file of thirty-two 128-bit vector registers. It also moves single 16-bit elements between a vector register and a 32-bit scalar value. Each operation is started by a one-cycle `start` pulse. The pulse carries an instruction word, the value of the scalar base register, the scalar operand and a 2-bit operation code. While the block works, `busy` is high. A single-cycle `done` pulse marks the end of every operation.

A quad operation forms an effective address and moves one byte per cycle. It starts at that address and runs up to the last byte of the same 16-byte line. On the vector side it starts at the element byte named in the instruction. A load stops early once vector byte 15 has been filled. A store wraps its vector byte index modulo 16. Vector byte n sits in physical lane 15−n, so byte 0 is the most significant byte of the register.

The memory is outside the block and has a synchronous read port with one cycle of latency. The FSM has six states:
- `ST_IDLE`: waits for `start`. It goes to `ST_LOAD`, `ST_STORE` or `ST_MOVE` according to the operation code.
- `ST_LOAD`: issues one read per cycle. After the last read it goes to `ST_LDRAIN`.
- `ST_LDRAIN`: writes the final returned byte into the register, then goes to `ST_FINISH`.
- `ST_STORE`: issues one write per cycle. After the last write it goes to `ST_FINISH`.
- `ST_MOVE`: performs an element move in one cycle, then goes to `ST_FINISH`.
- `ST_FINISH`: raises `done`, then returns to `ST_IDLE`.

Top module: `vq_lsu`

## Requirements
- R1: After reset, `busy`, `done`, `mem_re` and `mem_we` are 0, `scalar_out` is 0 and every vector register reads as zero.
- R2: The effective address is the base value plus the sign-extended 7-bit field instr[6:0] shifted left by 4, taken modulo 4096. The first memory access of a quad operation uses this address. `base_sel` always shows instr[25:21].
- R3: A quad load (op 2'b00) targets the register in instr[20:16] and starts at element e = instr[10:7]. It writes vector byte e+i from address ea+i. It performs min(16−ea[3:0], 16−e) reads, and no other byte of the register changes.
- R4: A quad store (op 2'b01) writes every address from ea to the end of its 16-byte line, which is 16−ea[3:0] writes. Address ea+i receives vector byte (e+i) mod 16. No address outside that range is written.
- R5: A vector-to-scalar move (op 2'b10) reads register instr[15:11]. It forms a 16-bit value from byte e (high half) and byte (e+1) mod 16 (low half), and puts it on `scalar_out` sign-extended to 32 bits, where it is valid with `done`.
- R6: A scalar-to-vector move (op 2'b11) writes scalar_in[15:8] to byte e of register instr[15:11]. It writes scalar_in[7:0] to byte e+1 only when e < 15; with e = 15, byte 0 keeps its value.
- R7: `done` is a one-cycle pulse, after which the block is idle. Counted from the clock edge that samples `start`, `done` is seen after n+2 cycles for a load of n bytes, n+1 cycles for a store of n bytes, and 2 cycles for a move.
- R8: A `start` pulse while `busy` is high is ignored. It changes no register, causes no extra `done` and does not change the running operation.
- R9: `mem_re` and `mem_we` are never high together. Successive accesses within one operation step the address by one and never leave the starting line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in idle only) |
| op_i | input | 2 | 00 quad load, 01 quad store, 10 vector-to-scalar, 11 scalar-to-vector |
| instr | input | 32 | Instruction word carrying the register, element and offset fields |
| base_val | input | 32 | Value of the scalar base register |
| scalar_in | input | 32 | Scalar operand for a scalar-to-vector move |
| base_sel | output | 5 | Index of the base scalar register, from instr[25:21] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| scalar_out | output | 32 | Result of a vector-to-scalar move |
| mem_addr | output | 12 | Data memory byte address |
| mem_re | output | 1 | Memory read request (data returned next cycle) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory, one cycle after `mem_re` |

## Verification
Loads are tried in three cases:
- An aligned address with element 0, which fills the whole register.
- A nonzero element on an aligned line, where the vector end clips the transfer.
- An address in mid-line, where the line end clips it.

Together these show which of the two limits decides the byte count. A negative offset from a small base checks the sign extension and the wrap modulo 4096.

Stores are tried in three matching cases: aligned, with an element that forces the vector index to wrap, and near the line end. Bytes just outside the line are also checked, to show that nothing spills over.

Element moves use even elements, an odd element and element 15. Element 15 is the case that separates the clipping rule of the scalar-to-vector move from the wrapping rule of the vector-to-scalar move. A start pulse raised in mid-load checks that the running transfer is undisturbed.

// File: rtl/vq_pkg.sv
package vq_pkg;

    typedef enum logic [1:0] {
        OP_QLOAD  = 2'b00,
        OP_QSTORE = 2'b01,
        OP_V2S    = 2'b10,
        OP_S2V    = 2'b11
    } vq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LDRAIN,
        ST_STORE,
        ST_MOVE,
        ST_FINISH
    } vq_state_e;

    // instruction field positions
    localparam int F_OFF_LO  = 0;
    localparam int F_E_LO    = 7;
    localparam int F_VM_LO   = 11;
    localparam int F_VQ_LO   = 16;
    localparam int F_BASE_LO = 21;

endpackage

// File: rtl/vq_addr_gen.sv
module vq_addr_gen #(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 7,
    parameter int LINE_B = 16,
    localparam int LANE_W = $clog2(LINE_B)
) (
    input  logic [ADDR_W-1:0] base_lo,
    input  logic [OFF_W-1:0]  off,
    input  logic [LANE_W-1:0] elem,
    input  logic              is_load,
    output logic [ADDR_W-1:0] ea,
    output logic [LANE_W:0]   count
);
    localparam logic [LANE_W:0] FULL = (LANE_W+1)'(LINE_B);

    logic [ADDR_W-1:0] disp;
    logic [LANE_W:0]   room_mem;
    logic [LANE_W:0]   room_vec;

    assign disp     = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off} << LANE_W;
    assign ea       = base_lo + disp;
    assign room_mem = FULL - {1'b0, ea[LANE_W-1:0]};
    assign room_vec = FULL - {1'b0, elem};

    always_comb begin
        if (is_load && (room_vec < room_mem)) count = room_vec;
        else                                  count = room_mem;
    end
endmodule

// File: rtl/vq_vreg_file.sv
module vq_vreg_file #(
    parameter int NREG   = 32,
    parameter int LINE_B = 16,
    localparam int LANE_W = $clog2(LINE_B),
    localparam int SEL_W  = $clog2(NREG),
    localparam int VW     = LINE_B * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [VW-1:0]     rd_vec,
    input  logic              wa_en,
    input  logic [SEL_W-1:0]  wa_sel,
    input  logic [LANE_W-1:0] wa_byte,
    input  logic [7:0]        wa_data,
    input  logic              wb_en,
    input  logic [SEL_W-1:0]  wb_sel,
    input  logic [LANE_W-1:0] wb_byte,
    input  logic [7:0]        wb_data
);
    logic [VW-1:0] regs [NREG];

    assign rd_vec = regs[rd_sel];

    // logical byte n lives in physical lane LINE_B-1-n, i.e. ~n
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) regs[r] <= '0;
        end else begin
            if (wa_en) regs[wa_sel][{~wa_byte, 3'b000} +: 8] <= wa_data;
            if (wb_en) regs[wb_sel][{~wb_byte, 3'b000} +: 8] <= wb_data;
        end
    end
endmodule

// File: rtl/vq_move_unit.sv
module vq_move_unit #(
    parameter int LINE_B = 16,
    parameter int XLEN   = 32,
    localparam int LANE_W = $clog2(LINE_B),
    localparam int VW     = LINE_B * 8
) (
    input  logic [VW-1:0]     vec,
    input  logic [LANE_W-1:0] elem,
    input  logic [15:0]       scal_lo,
    output logic [XLEN-1:0]   to_scalar,
    output logic [7:0]        hi_byte,
    output logic [7:0]        lo_byte,
    output logic [LANE_W-1:0] lo_pos,
    output logic              lo_en
);
    logic [LANE_W-1:0] nxt;
    logic [7:0]        rd_hi;
    logic [7:0]        rd_lo;

    assign nxt       = elem + 1'b1;          // wraps modulo LINE_B
    assign rd_hi     = vec[{~elem, 3'b000} +: 8];
    assign rd_lo     = vec[{~nxt, 3'b000} +: 8];
    assign to_scalar = {{(XLEN-16){rd_hi[7]}}, rd_hi, rd_lo};

    assign hi_byte = scal_lo[15:8];
    assign lo_byte = scal_lo[7:0];
    assign lo_pos  = nxt;
    assign lo_en   = (elem != {LANE_W{1'b1}});
endmodule

// File: rtl/vq_lsu.sv
module vq_lsu
    import vq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int XLEN   = 32,
    parameter int NREG   = 32,
    parameter int LINE_B = 16,
    parameter int OFF_W  = 7,
    localparam int LANE_W = $clog2(LINE_B),
    localparam int SEL_W  = $clog2(NREG),
    localparam int VW     = LINE_B * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_i,
    input  logic [31:0]       instr,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   scalar_in,
    output logic [4:0]        base_sel,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   scalar_out,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    vq_state_e state_q, state_d;
    vq_op_e    op_in, op_q;

    logic [SEL_W-1:0]  vsel_q;
    logic [LANE_W-1:0] e_q;
    logic [ADDR_W-1:0] ea_q;
    logic [LANE_W:0]   cnt_q;
    logic [LANE_W-1:0] idx_q;
    logic [15:0]       scal_q;
    logic              pend_v;
    logic [LANE_W-1:0] pend_byte;
    logic [XLEN-1:0]   sout_q;

    logic [ADDR_W-1:0] ea_w;
    logic [LANE_W:0]   cnt_w;
    logic              last_xfer;
    logic              accept;
    logic [SEL_W-1:0]  vsel_w;

    logic [VW-1:0]     rd_vec;
    logic [XLEN-1:0]   v2s_val;
    logic [7:0]        mv_hi, mv_lo;
    logic [LANE_W-1:0] mv_lo_pos;
    logic              mv_lo_en;
    logic              wa_en, wb_en;
    logic [LANE_W-1:0] wa_byte;
    logic [7:0]        wa_data;
    logic [LANE_W-1:0] cur_byte;

    logic unused_bits;
    assign unused_bits = ^{instr[31:26], base_val[XLEN-1:ADDR_W], scalar_in[XLEN-1:16]};

    assign op_in    = vq_op_e'(op_i);
    assign base_sel = instr[F_BASE_LO +: 5];
    assign accept   = (state_q == ST_IDLE) && start;
    assign vsel_w   = (op_in == OP_V2S || op_in == OP_S2V) ? instr[F_VM_LO +: SEL_W]
                                                           : instr[F_VQ_LO +: SEL_W];
    assign last_xfer = ({1'b0, idx_q} + 1'b1) == cnt_q;

    vq_addr_gen #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_B(LINE_B)
    ) u_addr (
        .base_lo (base_val[ADDR_W-1:0]),
        .off     (instr[F_OFF_LO +: OFF_W]),
        .elem    (instr[F_E_LO +: LANE_W]),
        .is_load (op_in == OP_QLOAD),
        .ea      (ea_w),
        .count   (cnt_w)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (op_in)
                        OP_QLOAD:  state_d = ST_LOAD;
                        OP_QSTORE: state_d = ST_STORE;
                        default:   state_d = ST_MOVE;
                    endcase
                end
            end
            ST_LOAD:   if (last_xfer) state_d = ST_LDRAIN;
            ST_LDRAIN: state_d = ST_FINISH;
            ST_STORE:  if (last_xfer) state_d = ST_FINISH;
            ST_MOVE:   state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- FSM outputs ----------------
    always_comb begin
        mem_re = 1'b0;
        mem_we = 1'b0;
        done   = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy   = 1'b0;
            ST_LOAD:   mem_re = 1'b1;
            ST_STORE:  mem_we = 1'b1;
            ST_FINISH: done   = 1'b1;
            default:   ;
        endcase
    end

    // ---------------- operation context ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_QLOAD;
            vsel_q    <= '0;
            e_q       <= '0;
            ea_q      <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            scal_q    <= '0;
            pend_v    <= 1'b0;
            pend_byte <= '0;
            sout_q    <= '0;
        end else begin
            if (accept) begin
                op_q   <= op_in;
                vsel_q <= vsel_w;
                e_q    <= instr[F_E_LO +: LANE_W];
                ea_q   <= ea_w;
                cnt_q  <= cnt_w;
                idx_q  <= '0;
                scal_q <= scalar_in[15:0];
            end else if (state_q == ST_LOAD || state_q == ST_STORE) begin
                idx_q <= idx_q + 1'b1;
            end
            pend_v    <= (state_q == ST_LOAD);
            pend_byte <= cur_byte;
            if (state_q == ST_MOVE && op_q == OP_V2S) sout_q <= v2s_val;
        end
    end

    // ---------------- datapath ----------------
    assign cur_byte   = e_q + idx_q;   // wraps modulo LINE_B for stores
    assign mem_addr   = {ea_q[ADDR_W-1:LANE_W], ea_q[LANE_W-1:0] + idx_q};
    assign mem_wdata  = rd_vec[{~cur_byte, 3'b000} +: 8];
    assign scalar_out = sout_q;

    vq_move_unit #(.LINE_B(LINE_B), .XLEN(XLEN)) u_move (
        .vec       (rd_vec),
        .elem      (e_q),
        .scal_lo   (scal_q),
        .to_scalar (v2s_val),
        .hi_byte   (mv_hi),
        .lo_byte   (mv_lo),
        .lo_pos    (mv_lo_pos),
        .lo_en     (mv_lo_en)
    );

    logic mv_write;
    assign mv_write = (state_q == ST_MOVE) && (op_q == OP_S2V);
    assign wa_en    = pend_v | mv_write;
    assign wa_byte  = pend_v ? pend_byte : e_q;
    assign wa_data  = pend_v ? mem_rdata : mv_hi;
    assign wb_en    = mv_write && mv_lo_en;

    vq_vreg_file #(.NREG(NREG), .LINE_B(LINE_B)) u_vrf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (vsel_q),
        .rd_vec  (rd_vec),
        .wa_en   (wa_en),
        .wa_sel  (vsel_q),
        .wa_byte (wa_byte),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_sel  (vsel_q),
        .wb_byte (mv_lo_pos),
        .wb_data (mv_lo)
    );
endmodule

// File: rtl/vq_lsu_chk.sv
module vq_lsu_chk #(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_re,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r9_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r9_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    a_r9_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    a_r4_same_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[ADDR_W-1:LANE_W] == $past(mem_addr[ADDR_W-1:LANE_W])));
endmodule

bind vq_lsu vq_lsu_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/vq_lsu_tb_top.sv
`timescale 1ns/1ps
module vq_lsu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] instr = '0, base_val = '0, scalar_in = '0;
    logic [4:0]  base_sel;
    logic        busy, done, mem_re, mem_we;
    logic [31:0] scalar_out;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    logic [7:0] mem [4096];
    logic [7:0] vm  [32][16];

    always #2.5 clk = ~clk;

    vq_lsu dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .instr(instr),
        .base_val(base_val), .scalar_in(scalar_in), .base_sel(base_sel),
        .busy(busy), .done(done), .scalar_out(scalar_out), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    // access monitor at the ports
    int   acc_cnt;
    logic [11:0] first_addr;
    always @(negedge clk) begin
        if (mem_re || mem_we) begin
            if (acc_cnt == 0) first_addr = mem_addr;
            acc_cnt = acc_cnt + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int bs, input int vq, input int vm_, input int e, input int off);
        mk = '0;
        mk[25:21] = 5'(bs);
        mk[20:16] = 5'(vq);
        mk[15:11] = 5'(vm_);
        mk[10:7]  = 4'(e);
        mk[6:0]   = 7'(off);
    endfunction

    function automatic logic [11:0] eff(input logic [31:0] b, input int off);
        logic [6:0]  o = 7'(off);
        logic [11:0] d = {{5{o[6]}}, o} << 4;
        eff = b[11:0] + d;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [31:0] ins, input logic [31:0] b,
                          input logic [31:0] s, output int lat, output logic [31:0] sout);
        @(negedge clk);
        acc_cnt = 0;
        op_i = op; instr = ins; base_val = b; scalar_in = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 1;
        while (!done && lat < 64) begin @(negedge clk); lat++; end
        sout = scalar_out;
    endtask

    task automatic put_elem(input int vr, input int e, input logic [15:0] v);
        int lat; logic [31:0] so;
        run_op(2'b11, mk(0, 0, vr, e, 0), 32'h0, {16'h0, v}, lat, so);
        check("R7 move-in latency", lat, 2);
        vm[vr][e] = v[15:8];
        if (e < 15) vm[vr][e+1] = v[7:0];
    endtask

    task automatic get_elem(input int vr, input int e, output logic [31:0] v);
        int lat;
        run_op(2'b10, mk(0, 0, vr, e, 0), 32'h0, 32'h0, lat, v);
        check("R7 move-out latency", lat, 2);
    endtask

    task automatic verify_vreg(input int vr, input string tag);
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            get_elem(vr, 2*k, v);
            check(tag, v, {{16{vm[vr][2*k][7]}}, vm[vr][2*k], vm[vr][2*k+1]});
        end
    endtask

    task automatic fill_vreg(input int vr, input int seed);
        for (int k = 0; k < 8; k++)
            put_elem(vr, 2*k, 16'((seed * 37 + k * 4721 + 16'h8A13) & 16'hFFFF));
    endtask

    task automatic t_load(input int vt, input int e, input int off, input logic [31:0] b, input string tag);
        int lat, n, a; logic [31:0] so; logic [11:0] ea;
        ea = eff(b, off); a = int'(ea[3:0]);
        n = (16 - a < 16 - e) ? 16 - a : 16 - e;
        for (int i = 0; i < n; i++) vm[vt][e+i] = mem[12'(ea + 12'(i))];
        run_op(2'b00, mk(3, vt, 0, e, off), b, 32'h0, lat, so);
        check({tag, " R2 first address"}, {20'h0, first_addr}, {20'h0, ea});
        check({tag, " R3 read count"}, acc_cnt, n);
        check({tag, " R7 load latency"}, lat, n + 2);
        verify_vreg(vt, {tag, " R3 register contents"});
    endtask

    task automatic t_store(input int vt, input int e, input int off, input logic [31:0] b, input string tag);
        int lat, a; logic [31:0] so; logic [11:0] ea, ln; logic [7:0] old [18];
        ea = eff(b, off); a = int'(ea[3:0]); ln = {ea[11:4], 4'h0};
        for (int i = -1; i < 17; i++) old[i+1] = mem[12'(ln + 12'(i))];
        run_op(2'b01, mk(3, vt, 0, e, off), b, 32'h0, lat, so);
        check({tag, " R2 first address"}, {20'h0, first_addr}, {20'h0, ea});
        check({tag, " R4 write count"}, acc_cnt, 16 - a);
        check({tag, " R7 store latency"}, lat, 16 - a + 1);
        for (int i = -1; i < 17; i++) begin
            logic [7:0] ex;
            if (i >= a && i < 16) ex = vm[vt][(e + i - a) % 16];
            else                  ex = old[i+1];
            check({tag, " R4 memory byte"}, {24'h0, mem[12'(ln + 12'(i))]}, {24'h0, ex});
        end
    endtask

    task automatic t_reset;
        check("R1 busy after reset", {31'h0, busy}, 32'h0);
        check("R1 done after reset", {31'h0, done}, 32'h0);
        check("R1 mem_re after reset", {31'h0, mem_re}, 32'h0);
        check("R1 mem_we after reset", {31'h0, mem_we}, 32'h0);
        check("R1 scalar_out after reset", scalar_out, 32'h0);
        verify_vreg(7, "R1 register cleared");
    endtask

    task automatic t_moves;
        logic [31:0] v;
        fill_vreg(1, 1); fill_vreg(2, 2); fill_vreg(3, 3);
        verify_vreg(1, "R6 filled reg1");
        verify_vreg(2, "R6 filled reg2");
        get_elem(2, 7, v);
        check("R5 odd element", v, {{16{vm[2][7][7]}}, vm[2][7], vm[2][8]});
        put_elem(1, 15, 16'h12EF);
        verify_vreg(1, "R6 element 15 leaves byte 0");
        get_elem(1, 15, v);
        check("R5 element 15 wraps to byte 0", v, {{16{vm[1][15][7]}}, vm[1][15], vm[1][0]});
        put_elem(3, 4, 16'h7F01);
        get_elem(3, 4, v);
        check("R5 positive sign extension", v, 32'h00007F01);
    endtask

    task automatic t_busy_ignore;
        int lat; logic [31:0] v; int extra;
        vm[4][0] = vm[4][0];
        @(negedge clk);
        acc_cnt = 0;
        op_i = 2'b00; instr = mk(3, 6, 0, 0, 0); base_val = 32'h700; start = 1'b1;
        for (int i = 0; i < 16; i++) vm[6][i] = mem[12'(12'h700 + 12'(i))];
        @(negedge clk); start = 1'b0; lat = 1;
        @(negedge clk); lat++;
        op_i = 2'b11; instr = mk(0, 0, 9, 0, 0); scalar_in = 32'h0000ABCD; start = 1'b1;
        @(negedge clk); start = 1'b0; lat++;
        while (!done && lat < 64) begin @(negedge clk); lat++; end
        check("R8 load latency unchanged", lat, 18);
        extra = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (done) extra++; end
        check("R8 no extra done", extra, 0);
        verify_vreg(9, "R8 ignored move left register");
        verify_vreg(6, "R8 running load intact");
        get_elem(9, 0, v);
        check("R8 register 9 byte 0", v, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 29 + 11) ^ (i >> 5));
        for (int r = 0; r < 32; r++) for (int b = 0; b < 16; b++) vm[r][b] = 8'h00;
        acc_cnt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        instr = mk(21, 0, 0, 0, 0);
        #1 check("R2 base_sel", {27'h0, base_sel}, 32'd21);
        t_moves();
        t_load(4, 0, 0, 32'h100, "aligned load");
        t_load(5, 5, 1, 32'h200, "element-clipped load");
        t_load(6, 2, 0, 32'h30A, "line-clipped load");
        t_load(8, 0, 7'h7F, 32'h005, "negative offset load");
        t_store(1, 0, 0, 32'h400, "aligned store");
        t_store(2, 9, 2, 32'h500, "wrapping store");
        t_store(3, 4, 0, 32'h60C, "line-end store");
        t_busy_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule